// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level table, a page directory and then a page table, and both tables sit in external memory. It reaches that memory through a single request/acknowledge port. A small direct-mapped translation cache holds combined entries, so a repeated page costs no memory traffic. During a walk the block sets the accessed bit of each entry it visits. It sets the dirty bit on writes. It writes an entry back to memory only when that entry's accessed bit was clear.

The requester presents one access at a time, and each access carries its privilege level, its direction and the paging and write-protect enables. The block answers with a one-cycle result. The result holds either a physical address or a page fault with a three-bit error code. A flush input empties the translation cache, for example after the tables have been changed.

Top module: `pgwalk_top`

## Requirements
- R1: With paging disabled for an access, the physical address equals the linear address and the block makes no memory access. The result appears two clocks after acceptance.
- R2: The directory entry is read at `{dir_base[31:12], lin[31:22], 2'b00}`. The table entry is read at `{dir_entry[31:12], lin[21:12], 2'b00}`. A successful result is `{entry[31:12], lin[11:0]}`.
- R3: Entry bits are laid out as follows: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bits 31:12 frame. A non-present directory entry or table entry gives a fault with code 0 and physical address 0. The walk stops at that entry.
- R4: When a visited entry's accessed bit is clear, the entry is written back with the bit set before the walk continues. When the bit is already set, no write-back takes place.
- R5: A write access sets the dirty bit in the table entry. That entry reaches memory only as part of an accessed-bit write-back.
- R6: The cached entry's writable and user bits are the AND of the directory bits and the table bits.
- R7: A fault is raised when the effective user bit is 0 and the privilege level is nonzero. A fault result carries physical address 0 and error code equal to bits 2:0 of the combined entry.
- R8: A write faults when write-protect is on and the effective writable bit is 0. The same write succeeds when write-protect is off.
- R9: A cache hit gives the result two clocks after acceptance, with no memory access. The cache is indexed by `lin[14:12]` (8 sets). A page that maps to the same set evicts the earlier one.
- R10: After reset, and after a flush pulse, every cache entry is invalid, so the next access to a page walks again.
- R11: `req_ready` is high only while the block is idle. `mem_req` and its address stay steady until `mem_ack`. `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_cpl | input | 2 | Current privilege level |
| pg_en | input | 1 | Paging enable, sampled at acceptance |
| wp_en | input | 1 | Write-protect enable, sampled at acceptance |
| dir_base | input | 32 | Page directory base (bits 31:12 used) |
| flush | input | 1 | Invalidate the whole translation cache |
| resp_valid | output | 1 | Result pulse |
| resp_phys | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Page fault |
| resp_code | output | 3 | Fault error code |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = entry write-back |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
A stale or wrongly combined cache entry shows up on the next hit to that page. It appears as a wrong physical address or a wrong fault code two clocks after acceptance, with no memory traffic to hint at the cause. A wrong walk state shows up sooner, at the memory port: an extra or missing write-back, a wrong entry address or a lost dirty bit. The bench counts the reads and writes of every access and compares the table memory against a behavioural shadow after each result. A cache that survives a flush, or that ignores set conflicts, shows up as a missing walk on the very next access to the page involved.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   localparam int LIN_W    = 32;
   localparam int PG_SH    = 12;
   localparam int VPN_W    = LIN_W - PG_SH;
   localparam int LVL_W    = 10;
   localparam int ENT_W    = 32;

   localparam int PTE_P = 0;
   localparam int PTE_W = 1;
   localparam int PTE_U = 2;
   localparam int PTE_A = 5;
   localparam int PTE_D = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_DIR_RD,
      ST_DIR_WB,
      ST_TBL_RD,
      ST_TBL_WB,
      ST_FILL,
      ST_DONE
   } walk_st_t;

   typedef struct packed {
      logic              fault;
      logic [2:0]        code;
      logic [LIN_W-1:0]  phys;
   } xlat_res_t;
endpackage

// File: rtl/pgwalk_tcache.sv
module pgwalk_tcache
   import pgwalk_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [ENT_W-1:0] hit_ent,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [ENT_W-1:0] fill_ent
);
   localparam int SETS  = 1 << IDX_W;
   localparam int TAG_W = VPN_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("pgwalk_tcache: IDX_W must lie in 1..10");
   end

   if (ENABLE) begin : g_on
      logic [SETS-1:0]  vld_q;
      logic [TAG_W-1:0] tag_q [SETS];
      logic [ENT_W-1:0] ent_q [SETS];
      logic [IDX_W-1:0] l_idx, f_idx;

      assign l_idx = look_vpn[IDX_W-1:0];
      assign f_idx = fill_vpn[IDX_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (flush) begin
            vld_q <= '0;
         end else if (fill_en) begin
            vld_q[f_idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en) begin
            tag_q[f_idx] <= fill_vpn[VPN_W-1:IDX_W];
            ent_q[f_idx] <= fill_ent;
         end
      end

      assign hit     = vld_q[l_idx] && (tag_q[l_idx] == look_vpn[VPN_W-1:IDX_W]);
      assign hit_ent = ent_q[l_idx];

      // R10: a flush leaves no valid entry behind
      p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
         flush |=> (vld_q == '0));

      // R3: only present entries are ever cached
      p_fill_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fill_en |-> fill_ent[PTE_P]);

      // R4: cached entries always carry the accessed bit
      p_fill_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
         fill_en |-> fill_ent[PTE_A]);
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, flush, look_vpn, fill_en, fill_vpn, fill_ent};
      assign hit       = 1'b0;
      assign hit_ent   = '0;
   end
endmodule

// File: rtl/pgwalk_entry.sv
module pgwalk_entry
   import pgwalk_pkg::*;
(
   input  logic             dir_w,
   input  logic             dir_u,
   input  logic [ENT_W-1:0] tbl_ent,
   input  logic             is_write,
   output logic [ENT_W-1:0] tbl_upd,
   output logic [ENT_W-1:0] eff_ent
);
   always_comb begin
      tbl_upd        = tbl_ent;
      tbl_upd[PTE_A] = 1'b1;
      if (is_write) begin
         tbl_upd[PTE_D] = 1'b1;
      end
      eff_ent        = tbl_upd;
      eff_ent[PTE_W] = tbl_upd[PTE_W] & dir_w;
      eff_ent[PTE_U] = tbl_upd[PTE_U] & dir_u;
   end
endmodule

// File: rtl/pgwalk_check.sv
module pgwalk_check
   import pgwalk_pkg::*;
(
   input  logic [ENT_W-1:0] ent,
   input  logic [PG_SH-1:0] offset,
   input  logic [1:0]       cpl,
   input  logic             is_write,
   input  logic             wp,
   output xlat_res_t        res
);
   logic user_viol;
   logic wr_viol;
   logic unused_mid;

   assign unused_mid = ^ent[PG_SH-1:3];
   assign user_viol  = !ent[PTE_U] && (cpl != 2'd0);
   assign wr_viol    = is_write && wp && !ent[PTE_W];

   always_comb begin
      res.fault = user_viol || wr_viol;
      res.code  = ent[2:0];
      res.phys  = res.fault ? '0 : {ent[ENT_W-1:PG_SH], offset};
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int TC_IDX_W = 3,
   parameter bit TC_EN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_lin,
   input  logic        req_write,
   input  logic [1:0]  req_cpl,
   input  logic        pg_en,
   input  logic        wp_en,
   input  logic [31:0] dir_base,
   input  logic        flush,
   output logic        resp_valid,
   output logic [31:0] resp_phys,
   output logic        resp_fault,
   output logic [2:0]  resp_code,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata
);
   localparam int DIR_HI = LIN_W - 1;
   localparam int DIR_LO = LIN_W - LVL_W;
   localparam int TBL_HI = DIR_LO - 1;
   localparam int TBL_LO = PG_SH;

   walk_st_t          st_q;
   logic [LIN_W-1:0]  lin_q;
   logic              wr_q;
   logic [1:0]        cpl_q;
   logic              pg_q;
   logic              wp_q;
   logic [VPN_W-1:0]  base_q;
   logic [ENT_W-1:0]  dir_q;
   logic [ENT_W-1:0]  tbl_q;
   xlat_res_t         res_q;

   logic              tc_hit;
   logic [ENT_W-1:0]  tc_ent;
   logic              fill_en;
   logic [ENT_W-1:0]  tbl_upd;
   logic [ENT_W-1:0]  eff_ent;
   logic [ENT_W-1:0]  chk_ent;
   xlat_res_t         chk_res;
   logic [LIN_W-1:0]  dir_addr;
   logic [LIN_W-1:0]  tbl_addr;

   assign dir_addr = {base_q, lin_q[DIR_HI:DIR_LO], 2'b00};
   assign tbl_addr = {dir_q[ENT_W-1:PG_SH], lin_q[TBL_HI:TBL_LO], 2'b00};
   assign fill_en  = (st_q == ST_FILL);
   assign chk_ent  = (st_q == ST_LOOK) ? tc_ent : eff_ent;

   pgwalk_tcache #(.IDX_W(TC_IDX_W), .ENABLE(TC_EN)) u_tcache (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .look_vpn (lin_q[LIN_W-1:PG_SH]),
      .hit      (tc_hit),
      .hit_ent  (tc_ent),
      .fill_en  (fill_en),
      .fill_vpn (lin_q[LIN_W-1:PG_SH]),
      .fill_ent (eff_ent)
   );

   pgwalk_entry u_entry (
      .dir_w    (dir_q[PTE_W]),
      .dir_u    (dir_q[PTE_U]),
      .tbl_ent  (tbl_q),
      .is_write (wr_q),
      .tbl_upd  (tbl_upd),
      .eff_ent  (eff_ent)
   );

   pgwalk_check u_check (
      .ent      (chk_ent),
      .offset   (lin_q[PG_SH-1:0]),
      .cpl      (cpl_q),
      .is_write (wr_q),
      .wp       (wp_q),
      .res      (chk_res)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = dir_addr;
      mem_wdata = '0;
      unique case (st_q)
         ST_DIR_RD: begin
            mem_req = 1'b1;
         end
         ST_DIR_WB: begin
            mem_req          = 1'b1;
            mem_we           = 1'b1;
            mem_wdata        = dir_q;
            mem_wdata[PTE_A] = 1'b1;
         end
         ST_TBL_RD: begin
            mem_req  = 1'b1;
            mem_addr = tbl_addr;
         end
         ST_TBL_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tbl_addr;
            mem_wdata = tbl_upd;
         end
         default: begin
            mem_req = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         lin_q  <= '0;
         wr_q   <= 1'b0;
         cpl_q  <= '0;
         pg_q   <= 1'b0;
         wp_q   <= 1'b0;
         base_q <= '0;
         dir_q  <= '0;
         tbl_q  <= '0;
         res_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q  <= req_lin;
                  wr_q   <= req_write;
                  cpl_q  <= req_cpl;
                  pg_q   <= pg_en;
                  wp_q   <= wp_en;
                  base_q <= dir_base[LIN_W-1:PG_SH];
                  st_q   <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (!pg_q) begin
                  res_q <= '{fault: 1'b0, code: 3'd0, phys: lin_q};
                  st_q  <= ST_DONE;
               end else if (tc_hit) begin
                  res_q <= chk_res;
                  st_q  <= ST_DONE;
               end else begin
                  st_q <= ST_DIR_RD;
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  dir_q <= mem_rdata;
                  if (!mem_rdata[PTE_P]) begin
                     res_q <= '{fault: 1'b1, code: 3'd0, phys: '0};
                     st_q  <= ST_DONE;
                  end else if (!mem_rdata[PTE_A]) begin
                     st_q <= ST_DIR_WB;
                  end else begin
                     st_q <= ST_TBL_RD;
                  end
               end
            end
            ST_DIR_WB: begin
               if (mem_ack) begin
                  dir_q[PTE_A] <= 1'b1;
                  st_q         <= ST_TBL_RD;
               end
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  tbl_q <= mem_rdata;
                  if (!mem_rdata[PTE_P]) begin
                     res_q <= '{fault: 1'b1, code: 3'd0, phys: '0};
                     st_q  <= ST_DONE;
                  end else if (!mem_rdata[PTE_A]) begin
                     st_q <= ST_TBL_WB;
                  end else begin
                     st_q <= ST_FILL;
                  end
               end
            end
            ST_TBL_WB: begin
               if (mem_ack) begin
                  st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               res_q <= chk_res;
               st_q  <= ST_DONE;
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign resp_valid = (st_q == ST_DONE);
   assign resp_phys  = res_q.phys;
   assign resp_fault = res_q.fault;
   assign resp_code  = res_q.code;

   // R11: a memory request holds its address and direction until acknowledged
   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R11: the result is a single-cycle pulse
   p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R11: an accepted request makes the block busy
   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R1: no memory traffic for an access with paging disabled
   p_off_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> pg_q);

   // R4: every write-back carries the accessed bit set
   p_wb_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[PTE_A]);

   // R6: a cached entry is never more permissive than its directory entry
   p_comb_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> ((!eff_ent[PTE_W] || dir_q[PTE_W]) && (!eff_ent[PTE_U] || dir_q[PTE_U])));

   // R7: a fault never reports a physical address
   p_fault_nophys_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> (resp_phys == '0));

   // R9: a hit in the lookup cycle issues no memory access next cycle
   p_hit_nomem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOOK && pg_q && tc_hit) |=> !mem_req);
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
   localparam int SETS = 8;
   localparam logic [31:0] BASE = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write, pg_en, wp_en, flush;
   logic [31:0] req_lin, dir_base;
   logic [1:0]  req_cpl;
   logic        resp_valid, resp_fault;
   logic [31:0] resp_phys;
   logic [2:0]  resp_code;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #4 clk = ~clk;

   pgwalk_top #(.TC_IDX_W(3), .TC_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_lin(req_lin), .req_write(req_write), .req_cpl(req_cpl), .pg_en(pg_en),
      .wp_en(wp_en), .dir_base(dir_base), .flush(flush), .resp_valid(resp_valid),
      .resp_phys(resp_phys), .resp_fault(resp_fault), .resp_code(resp_code),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   logic [31:0] mem     [int unsigned];
   logic [31:0] exp_mem [int unsigned];
   int          rd_cnt = 0, wr_cnt = 0;
   int          n_chk = 0, n_bad = 0;
   bit          expecting = 1'b0;
   bit          mv   [SETS];
   logic [19:0] mtag [SETS];
   logic [31:0] ment [SETS];

   task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   // memory responder: one-cycle acknowledge, idle cycle between accesses
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
         if (mem_we) begin
            mem[mem_addr >> 2] = mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata = mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
            rd_cnt++;
         end
         mem_ack = 1'b1;
      end
   end

   // R11: no result pulse outside an outstanding access
   always @(negedge clk) begin
      if (rst_n && resp_valid && !expecting) chk("R11", "unexpected resp_valid", 32'd1, 32'd0);
   end

   function automatic logic [31:0] shadow_rd(input logic [31:0] a);
      return exp_mem.exists(a >> 2) ? exp_mem[a >> 2] : 32'h0;
   endfunction

   task automatic put(input logic [31:0] a, input logic [31:0] v);
      mem[a >> 2]     = v;
      exp_mem[a >> 2] = v;
   endtask

   task automatic xlat(input string r, input logic [31:0] la, input bit wr,
                       input logic [1:0] cpl, input bit pg, input bit wp, input bit chk_lat);
      logic [31:0] e, pde, pte, pa, pdea, ptea;
      bit          flt, done;
      logic [2:0]  ec;
      int          nrd, nwr, lat, rd0, wr0, s;
      nrd = 0; nwr = 0; flt = 0; ec = 0; pa = 0; done = 0; e = 0;
      s = int'(la[14:12]);
      if (!pg) begin
         pa = la; done = 1;
      end else if (mv[s] && mtag[s] == la[31:12]) begin
         e = ment[s];
      end else begin
         pdea = {BASE[31:12], 12'h0} + {20'h0, la[31:22], 2'b00};
         pde  = shadow_rd(pdea); nrd = 1;
         if (!pde[0]) begin
            flt = 1; done = 1;
         end else begin
            if (!pde[5]) begin pde[5] = 1; exp_mem[pdea >> 2] = pde; nwr++; end
            ptea = {pde[31:12], 12'h0} + {20'h0, la[21:12], 2'b00};
            pte  = shadow_rd(ptea); nrd = 2;
            if (!pte[0]) begin
               flt = 1; done = 1;
            end else begin
               if (wr) pte[6] = 1;
               if (!pte[5]) begin pte[5] = 1; exp_mem[ptea >> 2] = pte; nwr++; end
               e = pte; e[1] = pte[1] & pde[1]; e[2] = pte[2] & pde[2];
               mv[s] = 1; mtag[s] = la[31:12]; ment[s] = e;
            end
         end
      end
      if (!done) begin
         flt = (!e[2] && cpl != 0) || (wr && wp && !e[1]);
         ec  = e[2:0];
         pa  = flt ? 32'h0 : {e[31:12], la[11:0]};
      end

      @(negedge clk);
      lat = 0;
      while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
      rd0 = rd_cnt; wr0 = wr_cnt;
      req_valid = 1; req_lin = la; req_write = wr; req_cpl = cpl; pg_en = pg; wp_en = wp;
      expecting = 1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; lat = 1;
      while (!resp_valid && lat < 200) begin @(negedge clk); lat++; end
      if (!resp_valid) begin
         chk(r, "no response", 32'd0, 32'd1);
      end else begin
         chk(r, "fault", {31'd0, resp_fault}, {31'd0, flt});
         chk(r, "code", {29'd0, resp_code}, {29'd0, ec});
         chk(r, "phys", resp_phys, pa);
         chk(r, "reads", rd_cnt - rd0, nrd);
         chk(r, "writes", wr_cnt - wr0, nwr);
         if (chk_lat) chk(r, "latency", lat, 2);
         foreach (exp_mem[k]) chk(r, "table memory", mem[k], exp_mem[k]);
      end
      @(posedge clk);
      #1 expecting = 0;
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
      for (int i = 0; i < SETS; i++) mv[i] = 0;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; req_valid = 0; req_lin = 0; req_write = 0; req_cpl = 0;
      pg_en = 0; wp_en = 0; dir_base = BASE; flush = 0; mem_ack = 0; mem_rdata = 0;
      for (int i = 0; i < SETS; i++) begin mv[i] = 0; mtag[i] = 0; ment[i] = 0; end
      // directory: idx1 -> table 0x20000 (W,U, A clear); idx2 -> table 0x30000 (read-only, supervisor, A set)
      put(BASE + 4*1, 32'h0002_0007);
      put(BASE + 4*2, 32'h0003_0021);
      put(32'h2_0000 + 4*3,  32'hABCD_E007);
      put(32'h2_0000 + 4*4,  32'h1111_1027);
      put(32'h2_0000 + 4*5,  32'h2222_2007);
      put(32'h2_0000 + 4*11, 32'h3333_3027);
      put(32'h2_0000 + 4*6,  32'h4444_4027);
      put(32'h3_0000 + 4*0,  32'h5555_5027);
      repeat (3) @(negedge clk);
      // R11 / R10: reset state
      chk("R11", "reset req_ready", {31'd0, req_ready}, 32'd1);
      chk("R11", "reset resp_valid", {31'd0, resp_valid}, 32'd0);
      chk("R11", "reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      xlat("R1", 32'h1234_5678, 0, 3, 0, 0, 1);           // paging off
      xlat("R2", 32'h0040_3456, 0, 3, 1, 0, 0);           // walk, both A clear (R4)
      xlat("R9", 32'h0040_3ABC, 0, 3, 1, 0, 1);           // hit, no memory
      xlat("R5", 32'h0040_4010, 1, 0, 1, 1, 0);           // write, A set: D not written
      xlat("R5", 32'h0040_5020, 1, 0, 1, 1, 0);           // write, A clear: A and D written
      xlat("R4", 32'h0040_6000, 0, 0, 1, 0, 0);           // all accessed bits set
      xlat("R6", 32'h0080_0123, 0, 0, 1, 0, 0);           // combined read-only supervisor
      xlat("R8", 32'h0080_0123, 1, 0, 1, 1, 1);           // write-protect fault on hit
      xlat("R8", 32'h0080_0124, 1, 0, 1, 0, 1);           // write-protect off: allowed
      xlat("R7", 32'h0080_0125, 0, 3, 1, 0, 1);           // user on supervisor page
      xlat("R7", 32'h0080_0126, 0, 2, 1, 0, 1);           // privilege 2 also user
      xlat("R3", 32'h01C0_0000, 0, 0, 1, 0, 0);           // directory not present
      xlat("R3", 32'h0040_9000, 0, 0, 1, 0, 0);           // table not present
      xlat("R9", 32'h0040_B000, 0, 3, 1, 0, 0);           // same set as page 0x403: evicts
      xlat("R9", 32'h0040_3000, 0, 3, 1, 0, 0);           // walks again after eviction
      do_flush();
      xlat("R10", 32'h0040_3004, 0, 3, 1, 0, 0);          // walks again after flush
      xlat("R10", 32'h0040_3008, 1, 3, 1, 1, 1);          // refilled entry hits
      xlat("R1", 32'h0080_0123, 1, 3, 0, 1, 1);           // paging off ignores protection

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule